// File: doc/BRIEF.md
# Double-Buffered Display Register Commit Controller

This block holds the configuration registers of a display engine in two copies. The host writes through a plain register bus into a pending bank. The datapath only ever sees the active bank. The active bank takes the pending values only at the rising edge of the vertical blanking signal, so a half-written configuration never shows up in the middle of a frame.

Two policies choose whether a blanking edge moves data. In automatic mode every blanking edge copies the whole pending bank. In explicit mode (the reset default) a copy happens only after the host sets a commit request. That request reads back as set until the copy has happened, so software can poll it before it starts the next batch of writes. A self-clearing clear bit zeroes the pending bank, which gives the registers known contents after initialization. Host reads return pending values. A separate debug selector shows any active register.

The register bus uses byte addresses with 32-bit registers on a 4-byte stride. Offset 0x0 is the control register. Configuration register k sits at offset 4*(k+1).

Top module: `dbuf_commit_ctrl`

## Requirements
- R1: After reset every pending and active register is zero, `commit_busy` and `load_done` are 0, and the control register reads 0x2 (explicit mode).
- R2: A write to configuration register k at byte offset 4*(k+1) is visible on `rd_data` at that offset from the next cycle on. The active copy does not change without a blanking edge.
- R3: Writing control bit 0 as 1 sets the commit request. It reads as 1 on `rd_data` bit 0 and on `commit_busy` until the blanking edge that performs the copy, and it reads 0 from the cycle after that edge.
- R4: With control bit 1 (autoload disable) at 1 and no commit request pending, a blanking rising edge leaves the active bank unchanged and gives no `load_done`.
- R5: A blanking rising edge with a commit request pending copies every pending register into the active bank. The new values show on `cfg_active` and `load_done` pulses for one cycle, both in the cycle after the edge.
- R6: With control bit 1 at 0, every blanking rising edge copies the bank, whether or not a commit request is pending.
- R7: A configuration write in the same cycle as a copying edge updates the pending register. The active bank takes the old pending value, and the new value moves at the next copying edge.
- R8: Only a 0-to-1 transition of `vblank` counts as an edge. Holding `vblank` high copies nothing further.
- R9: Writing control bit 2 as 1 zeroes every pending register in one cycle. The active bank is untouched until a later copy. Bit 2 always reads 0.
- R10: `dbg_data` returns the active value of register `dbg_sel`, and 0 for a selector of NUM_REGS or more.
- R11: Writes to a misaligned byte address, or to an offset beyond the last register, change nothing. Reads of such addresses return 0.
- R12: A commit request written in the same cycle as a blanking rising edge stays set and is serviced at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank | input | 1 | Vertical blanking level, synchronous to clk |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | DATA_W | Combinational read data (pending values or control) |
| dbg_sel | input | clog2(NUM_REGS+1) | Debug register selector |
| dbg_data | output | DATA_W | Active value of the selected register |
| cfg_active | output | NUM_REGS*DATA_W | Active bank to the datapath, register k at bits k*DATA_W |
| commit_busy | output | 1 | Commit request pending |
| load_done | output | 1 | One-cycle pulse after a copy |

## Verification
The hardest situations to reach are the ones where a host action lands in exactly the cycle of a blanking edge. These are a configuration write racing the copy, and a commit request arriving as the edge it would miss is processed. The bench drives `vblank` and the host write from the same falling clock edge, so both reach the same rising edge. A cycle-level model then predicts the active bank, the pending bank and the commit bit after every cycle. Sweeps over every register and several data patterns, in both copy policies, cover the ordinary paths around these races.

// File: rtl/dbuf_pkg.sv
`timescale 1ns/1ps
package dbuf_pkg;
  localparam int CTL_COMMIT  = 0;
  localparam int CTL_AUTOOFF = 1;
  localparam int CTL_CLEAR   = 2;

  typedef struct packed {
    logic clear;
    logic autooff;
    logic commit;
  } ctl_bits_t;
endpackage

// File: rtl/dbuf_addr_dec.sv
`timescale 1ns/1ps
module dbuf_addr_dec #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_ctl,
  output logic              is_cfg,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] word_m1;
  logic              aligned;

  always_comb begin
    word    = addr[ADDR_W-1:2];
    word_m1 = word - WORD_W'(1);
    aligned = (addr[1:0] == 2'b00);
    is_ctl  = aligned && (word == '0);
    is_cfg  = aligned && (word != '0) && (word <= WORD_W'(NUM_REGS));
    idx     = word_m1[IDX_W-1:0];
  end
endmodule

// File: rtl/dbuf_vblank_edge.sv
`timescale 1ns/1ps
module dbuf_vblank_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank,
  output logic rise
);
  logic vb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vb_q <= 1'b0;
    else        vb_q <= vblank;
  end

  assign rise = vblank & ~vb_q;
endmodule

// File: rtl/dbuf_commit_fsm.sv
`timescale 1ns/1ps
module dbuf_commit_fsm
  import dbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_we,
  input  ctl_bits_t ctl_wdata,
  input  logic      rise,
  output logic      busy,
  output logic      autooff,
  output logic      copy_now,
  output logic      clear_now,
  output logic      done
);
  assign copy_now  = rise & (busy | ~autooff);
  assign clear_now = ctl_we & ctl_wdata.clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      autooff <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= copy_now;
      if (ctl_we && ctl_wdata.commit) busy <= 1'b1;
      else if (copy_now)              busy <= 1'b0;
      if (ctl_we) autooff <= ctl_wdata.autooff;
    end
  end
endmodule

// File: rtl/dbuf_shadow_slot.sv
`timescale 1ns/1ps
module dbuf_shadow_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clear_now,
  input  logic              copy_now,
  output logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
    end else begin
      if (copy_now)       act  <= pend;
      if (clear_now)      pend <= '0;
      else if (we)        pend <= wdata;
    end
  end
endmodule

// File: rtl/dbuf_commit_ctrl.sv
`timescale 1ns/1ps
module dbuf_commit_ctrl
  import dbuf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  localparam int SEL_W   = $clog2(NUM_REGS + 1),
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vblank,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [SEL_W-1:0]           dbg_sel,
  output logic [DATA_W-1:0]          dbg_data,
  output logic [NUM_REGS*DATA_W-1:0] cfg_active,
  output logic                       commit_busy,
  output logic                       load_done
);
  logic             w_ctl, w_cfg, r_ctl, r_cfg;
  logic [IDX_W-1:0] w_idx, r_idx;
  logic             rise, copy_now, clear_now, auto_off;
  ctl_bits_t        ctl_wdata;
  logic [DATA_W-1:0] pend [NUM_REGS];
  logic [DATA_W-1:0] act  [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] pend_flat;

  dbuf_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_wdec (
    .addr(wr_addr), .is_ctl(w_ctl), .is_cfg(w_cfg), .idx(w_idx));

  dbuf_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rdec (
    .addr(rd_addr), .is_ctl(r_ctl), .is_cfg(r_cfg), .idx(r_idx));

  dbuf_vblank_edge u_edge (.clk(clk), .rst_n(rst_n), .vblank(vblank), .rise(rise));

  assign ctl_wdata = '{clear:   wr_data[CTL_CLEAR],
                       autooff: wr_data[CTL_AUTOOFF],
                       commit:  wr_data[CTL_COMMIT]};

  dbuf_commit_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_we(wr_en & w_ctl), .ctl_wdata(ctl_wdata),
    .rise(rise), .busy(commit_busy), .autooff(auto_off), .copy_now(copy_now),
    .clear_now(clear_now), .done(load_done));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    dbuf_shadow_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && w_cfg && (w_idx == IDX_W'(k))),
      .wdata(wr_data), .clear_now(clear_now), .copy_now(copy_now),
      .pend(pend[k]), .act(act[k]));
    assign cfg_active[k*DATA_W +: DATA_W] = act[k];
    assign pend_flat[k*DATA_W +: DATA_W]  = pend[k];
  end

  always_comb begin
    rd_data = '0;
    if (r_ctl) begin
      rd_data[CTL_COMMIT]  = commit_busy;
      rd_data[CTL_AUTOOFF] = auto_off;
    end else if (r_cfg) begin
      rd_data = pend[r_idx];
    end
  end

  always_comb begin
    dbg_data = '0;
    if (dbg_sel < SEL_W'(NUM_REGS)) dbg_data = act[dbg_sel[IDX_W-1:0]];
  end
endmodule

// File: rtl/dbuf_commit_chk.sv
`timescale 1ns/1ps
module dbuf_commit_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       vblank,
  input logic                       commit_busy,
  input logic                       load_done,
  input logic                       auto_off,
  input logic [NUM_REGS*DATA_W-1:0] cfg_active,
  input logic [NUM_REGS*DATA_W-1:0] pend_flat
);
  logic vb_seen;
  logic edge_c;

  always_ff @(posedge clk) begin
    if (!rst_n) vb_seen <= 1'b0;
    else        vb_seen <= vblank;
  end
  assign edge_c = vblank && !vb_seen;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_c |=> $stable(cfg_active)); // R8
  AST_NO_SPURIOUS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_c && auto_off && !commit_busy) |=> !load_done); // R4
  AST_AUTO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_c && !auto_off) |=> load_done); // R6
  AST_COMMIT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_c && commit_busy) |=> load_done); // R5
  AST_COMMIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_busy && !edge_c) |=> commit_busy); // R3
  AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (cfg_active == $past(pend_flat))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done); // R5
endmodule

bind dbuf_commit_ctrl dbuf_commit_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .commit_busy(commit_busy),
  .load_done(load_done), .auto_off(auto_off), .cfg_active(cfg_active),
  .pend_flat(pend_flat));

// File: tb/dbuf_commit_ctrl_tb.sv
`timescale 1ns/1ps
module dbuf_commit_ctrl_tb;
  localparam int NUM = 8;
  localparam int DW  = 32;
  localparam int AW  = 8;
  localparam int SW  = $clog2(NUM + 1);

  logic clk = 1'b0, rst_n = 1'b0, vblank = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [SW-1:0] dbg_sel = '0;
  logic [DW-1:0] rd_data, dbg_data;
  logic [NUM*DW-1:0] cfg_active;
  logic commit_busy, load_done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] m_pend [NUM];
  logic [DW-1:0] m_act  [NUM];
  logic m_busy, m_ao, m_done, m_vb;

  always #2.5 clk = ~clk;

  dbuf_commit_ctrl #(.NUM_REGS(NUM), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .vblank(vblank), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dbg_sel(dbg_sel),
    .dbg_data(dbg_data), .cfg_active(cfg_active), .commit_busy(commit_busy),
    .load_done(load_done));

  task automatic chk(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int k, int s);
    return (DW'(k + 1) * 32'h0101_0101) ^ (DW'(s + 1) * 32'h3C5A_9617);
  endfunction

  task automatic verify(string req);
    #0.5;
    chk(req, "load_done", DW'(load_done), DW'(m_done));
    chk(req, "commit_busy", DW'(commit_busy), DW'(m_busy));
    rd_addr = '0;
    #0.1;
    chk(req, "ctrl read", rd_data, {29'b0, 1'b0, m_ao, m_busy});
    for (int k = 0; k < NUM; k++) begin
      rd_addr = AW'(4 * (k + 1));
      dbg_sel = SW'(k);
      #0.1;
      chk(req, "pending read", rd_data, m_pend[k]);
      chk(req, "active bus", cfg_active[k*DW +: DW], m_act[k]);
      chk(req, "debug port", dbg_data, m_act[k]);
    end
  endtask

  // one clock cycle with given stimulus; model updated at the rising edge
  task automatic step(bit we, int addr, logic [DW-1:0] data, bit vb, string req);
    bit rise, copy;
    @(negedge clk);
    wr_en = we; wr_addr = AW'(addr); wr_data = data; vblank = vb;
    @(posedge clk);
    rise = vb && !m_vb;
    copy = rise && (m_busy || !m_ao);
    m_done = copy;
    if (copy) begin
      for (int k = 0; k < NUM; k++) m_act[k] = m_pend[k];
      m_busy = 1'b0;
    end
    if (we && addr == 0) begin
      if (data[0]) m_busy = 1'b1;
      m_ao = data[1];
      if (data[2]) for (int k = 0; k < NUM; k++) m_pend[k] = '0;
    end else if (we && (addr % 4) == 0 && addr >= 4 && addr <= 4 * NUM) begin
      m_pend[addr / 4 - 1] = data;
    end
    m_vb = vb;
    verify(req);
  endtask

  task automatic idle(string req);
    step(0, 0, '0, 0, req);
  endtask

  task automatic blank(string req);
    step(0, 0, '0, 1, req);
    step(0, 0, '0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NUM; k++) begin m_pend[k] = '0; m_act[k] = '0; end
    m_busy = 0; m_ao = 1; m_done = 0; m_vb = 0;
    repeat (3) @(posedge clk);
    #0.5 verify("R1");
    @(negedge clk); rst_n = 1'b1;
    idle("R1");

    // explicit mode sweeps
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < NUM; k++) step(1, 4 * (k + 1), pat(k, s), 0, "R2");
      blank("R4");
      step(1, 0, 32'h3, 0, "R3");
      idle("R3"); idle("R3");
      blank("R5");
      idle("R3");
    end

    // vblank held high: commit during high must wait for next rise
    step(1, 4, 32'hDEAD_0001, 0, "R8");
    step(0, 0, '0, 1, "R8");
    step(1, 0, 32'h3, 1, "R8");
    step(0, 0, '0, 1, "R8");
    step(0, 0, '0, 1, "R8");
    step(0, 0, '0, 0, "R8");
    step(0, 0, '0, 1, "R8");
    step(0, 0, '0, 0, "R8");

    // commit write racing the edge (explicit mode)
    step(1, 8, 32'hCAFE_0002, 0, "R12");
    step(1, 0, 32'h3, 1, "R12");
    step(0, 0, '0, 0, "R12");
    blank("R12");

    // automatic mode
    step(1, 0, 32'h0, 0, "R6");
    for (int s = 3; s < 6; s++) begin
      for (int k = 0; k < NUM; k++) step(1, 4 * (k + 1), pat(k, s), 0, "R6");
      blank("R6");
    end
    step(1, 0, 32'h1, 0, "R6");
    blank("R6");

    // write racing the copying edge
    step(1, 12, 32'h1234_5678, 0, "R7");
    step(1, 12, 32'h8765_4321, 1, "R7");
    step(0, 0, '0, 0, "R7");
    blank("R7");

    // clear of pending bank, back in explicit mode
    step(1, 0, 32'h2, 0, "R9");
    step(1, 0, 32'h6, 0, "R9");
    idle("R9");
    step(1, 0, 32'h3, 0, "R9");
    blank("R9");

    // address decode corners
    for (int k = 0; k < NUM; k++) step(1, 4 * (k + 1), pat(k, 7), 0, "R11");
    step(1, 5, 32'hFFFF_FFFF, 0, "R11");
    step(1, 4 * (NUM + 1), 32'hFFFF_FFFF, 0, "R11");
    step(1, 2, 32'hFFFF_FFFF, 0, "R11");
    step(1, 0, 32'h3, 0, "R10");
    blank("R10");
    #0.5;
    rd_addr = AW'(5); #0.1;
    chk("R11", "misaligned read", rd_data, '0);
    rd_addr = AW'(4 * (NUM + 1)); #0.1;
    chk("R11", "out-of-range read", rd_data, '0);
    dbg_sel = SW'(NUM); #0.1;
    chk("R10", "debug out-of-range", dbg_data, '0);
    dbg_sel = SW'(NUM - 1); #0.1;
    chk("R10", "debug last", dbg_data, pat(NUM - 1, 7));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule